// File: doc/BRIEF.md
# Sequencer-Gated Input Fault Recorder

This block keeps a record of which monitored inputs have reported a fault. Each input has one sticky bit. A bit is set only on a clock edge where the sequencer's capture-enable level is high. While the sequencer runs a deliberate shutdown, it drops that level, so the undervoltage trips the shutdown causes are not recorded as faults.

The bits are grouped into narrow host registers. With the default parameters, twelve inputs fill two 8-bit registers. A host reads a register to find out which inputs tripped, and writes ones to it to clear the bits it has handled. A summary output is high whenever any bit is held, which lets the sequencer or an interrupt line react without polling. Fault detection, the sequencer itself and the serial bus that carries the host accesses are all outside this block. The block sees only per-input fault strobes, the enable level and a simple register port.

Top module: `flt_capture_latch`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), every fault bit is 0, `any_fault` is 0 and `host_rdata` is 0.
- R2: If `capture_en` is 1 and `fault_strobe[i]` is 1 at a clock edge, bit i is set from that edge on.
- R3: A set bit stays set on every following edge, whatever the fault strobes do, until a host clear removes it.
- R4: While `capture_en` is 0 at an edge, the fault strobes change no bit at that edge.
- R5: A write (`host_wr`=1) to address a clears each bit of register a whose `host_wdata` bit is 1 and leaves the other bits unchanged. Input i maps to register i/8, bit i%8: inputs 0..7 are bits 7:0 of register 0, and inputs 8..11 are bits 3:0 of register 1.
- R6: If a captured fault and a host clear hit the same bit at the same edge, the bit ends up set.
- R7: If `host_rd` is 1 at an edge, `host_rdata` takes the value register `host_addr` held before that edge. Bits 7:4 of register 1 always read 0. When `host_rd` is 0, `host_rdata` holds its value.
- R8: `any_fault` is registered and, after every edge, equals the OR of all fault bits as updated by that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| capture_en | input | 1 | Capture-enable level for the current sequencer state |
| fault_strobe | input | NUM_INPUTS (12) | Per-input fault indication, sampled at each edge |
| host_wr | input | 1 | Write-one-to-clear strobe |
| host_rd | input | 1 | Read strobe |
| host_addr | input | ADDR_W (1) | Register index |
| host_wdata | input | REG_W (8) | Clear mask for the addressed register |
| host_rdata | output | REG_W (8) | Registered read data |
| any_fault | output | 1 | High while any fault bit is set |

## Verification
The hardest case to reach from the ports is an edge where a captured fault and a host clear land on the same bit, and a close second is a clear that arrives while capture is disabled and the same input is still strobing. The stimulus first sets the target bit. It then issues the clearing write in exactly the cycle the fault strobe fires with capture enabled. It repeats the same write with capture disabled and reads the register straight afterwards. A long random phase then mixes enable levels, strobes, clears and reads in the same cycles, and every result is compared with a behavioural model.

// File: rtl/flt_pkg.sv
package flt_pkg;
  function automatic int regs_for(input int n_inputs, input int reg_w);
    return (n_inputs + reg_w - 1) / reg_w;
  endfunction

  function automatic int addr_bits(input int n_regs);
    return (n_regs > 1) ? $clog2(n_regs) : 1;
  endfunction

  function automatic int live_bits(input int n_inputs, input int reg_w, input int idx);
    int rem;
    rem = n_inputs - idx * reg_w;
    if (rem > reg_w) return reg_w;
    if (rem < 0) return 0;
    return rem;
  endfunction
endpackage

// File: rtl/flt_reg_slice.sv
module flt_reg_slice #(
  parameter int REG_W = 8,
  parameter int LIVE  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [REG_W-1:0] hit,
  input  logic             clr_we,
  input  logic [REG_W-1:0] clr_mask,
  output logic [REG_W-1:0] bits,
  output logic [REG_W-1:0] bits_nxt
);
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (b < LIVE) begin : g_live
      logic q;
      logic d;
      always_comb begin
        if (cap_en && hit[b])          d = 1'b1;
        else if (clr_we && clr_mask[b]) d = 1'b0;
        else                           d = q;
      end
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
      end
      assign bits[b]     = q;
      assign bits_nxt[b] = d;
    end else begin : g_pad
      assign bits[b]     = 1'b0;
      assign bits_nxt[b] = 1'b0;
    end
  end
endmodule

// File: rtl/flt_read_port.sv
module flt_read_port #(
  parameter int REG_W    = 8,
  parameter int NUM_REGS = 2,
  parameter int ADDR_W   = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NUM_REGS*REG_W-1:0] flat,
  output logic [REG_W-1:0]          rdata
);
  logic [REG_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (int'(addr) == r) sel = flat[r*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel;
  end
endmodule

// File: rtl/flt_summary.sv
module flt_summary #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] nxt,
  output logic             any
);
  always_ff @(posedge clk) begin
    if (rst) any <= 1'b0;
    else     any <= |nxt;
  end
endmodule

// File: rtl/flt_capture_latch.sv
module flt_capture_latch #(
  parameter int NUM_INPUTS = 12,
  parameter int REG_W      = 8,
  parameter int NUM_REGS   = flt_pkg::regs_for(NUM_INPUTS, REG_W),
  parameter int ADDR_W     = flt_pkg::addr_bits(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  capture_en,
  input  logic [NUM_INPUTS-1:0] fault_strobe,
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [REG_W-1:0]      host_wdata,
  output logic [REG_W-1:0]      host_rdata,
  output logic                  any_fault
);
  localparam int TOTAL = NUM_REGS * REG_W;

  logic [TOTAL-1:0] hit_pad;
  logic [TOTAL-1:0] latched;
  logic [TOTAL-1:0] latched_nxt;

  always_comb begin
    hit_pad = '0;
    hit_pad[NUM_INPUTS-1:0] = fault_strobe;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam int LIVE = flt_pkg::live_bits(NUM_INPUTS, REG_W, r);
    logic clr_we;
    assign clr_we = host_wr && (int'(host_addr) == r);

    flt_reg_slice #(.REG_W(REG_W), .LIVE(LIVE)) u_slice (
      .clk      (clk),
      .rst      (rst),
      .cap_en   (capture_en),
      .hit      (hit_pad[r*REG_W +: REG_W]),
      .clr_we   (clr_we),
      .clr_mask (host_wdata),
      .bits     (latched[r*REG_W +: REG_W]),
      .bits_nxt (latched_nxt[r*REG_W +: REG_W])
    );
  end

  flt_read_port #(.REG_W(REG_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd    (host_rd),
    .addr  (host_addr),
    .flat  (latched),
    .rdata (host_rdata)
  );

  flt_summary #(.WIDTH(TOTAL)) u_sum (
    .clk (clk),
    .rst (rst),
    .nxt (latched_nxt),
    .any (any_fault)
  );
endmodule

// File: rtl/flt_capture_latch_chk.sv
module flt_capture_latch_chk #(
  parameter int NUM_INPUTS = 12,
  parameter int REG_W      = 8,
  parameter int TOTAL      = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  capture_en,
  input logic [NUM_INPUTS-1:0] fault_strobe,
  input logic                  host_wr,
  input logic                  host_rd,
  input logic [REG_W-1:0]      host_rdata,
  input logic                  any_fault,
  input logic [TOTAL-1:0]      latched
);
  logic [TOTAL-1:0] strobe_pad;
  always_comb begin
    strobe_pad = '0;
    strobe_pad[NUM_INPUTS-1:0] = fault_strobe;
  end

  // R2 and R6: an enabled strobe always leaves its bit set
  a_r2_capture_sets: assert property (@(posedge clk) disable iff (rst)
    capture_en |=> ((latched & $past(strobe_pad)) == $past(strobe_pad)));

  // R4: no new bits appear while capture is off
  a_r4_gate_blocks: assert property (@(posedge clk) disable iff (rst)
    !capture_en |=> ((latched & ~$past(latched)) == '0));

  // R3: without a write, no bit falls
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    !host_wr |=> (($past(latched) & ~latched) == '0));

  // R7: read data holds without a read
  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));

  // R8: summary flag agrees with the stored bits
  a_r8_summary: assert property (@(posedge clk) disable iff (rst)
    any_fault == (|latched));
endmodule

bind flt_capture_latch flt_capture_latch_chk #(
  .NUM_INPUTS(NUM_INPUTS), .REG_W(REG_W), .TOTAL(TOTAL)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .capture_en   (capture_en),
  .fault_strobe (fault_strobe),
  .host_wr      (host_wr),
  .host_rd      (host_rd),
  .host_rdata   (host_rdata),
  .any_fault    (any_fault),
  .latched      (latched)
);

// File: tb/flt_capture_latch_tb.sv
module flt_capture_latch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 12;

  logic          clk = 1'b0;
  logic          rst;
  logic          capture_en;
  logic [NI-1:0] fault_strobe;
  logic          host_wr;
  logic          host_rd;
  logic [0:0]    host_addr;
  logic [7:0]    host_wdata;
  logic [7:0]    host_rdata;
  logic          any_fault;

  int total = 0;
  int bad = 0;

  bit       m_bits [NI];
  bit [7:0] m_rdata;
  bit       m_any;

  always #(CLK_PERIOD/2) clk = ~clk;

  flt_capture_latch u_dut (
    .clk(clk), .rst(rst), .capture_en(capture_en), .fault_strobe(fault_strobe),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .any_fault(any_fault)
  );

  function automatic bit [7:0] model_reg(input int a);
    bit [7:0] v = '0;
    for (int k = 0; k < 8; k++) begin
      int idx = a * 8 + k;
      if (idx < NI) v[k] = m_bits[idx];
    end
    return v;
  endfunction

  task automatic compare(input string tag);
    total++;
    if (host_rdata !== m_rdata) begin
      bad++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, host_rdata, m_rdata);
    end
    total++;
    if (any_fault !== m_any) begin
      bad++;
      $display("FAIL %s any_fault actual=%b expected=%b", tag, any_fault, m_any);
    end
  endtask

  task automatic step(input bit cap, input bit [NI-1:0] flt, input bit wr,
                      input int addr, input bit [7:0] wd, input bit rd, input string tag);
    capture_en = cap; fault_strobe = flt; host_wr = wr;
    host_addr = addr[0:0]; host_wdata = wd; host_rd = rd;
    @(posedge clk);
    if (rd) m_rdata = model_reg(addr);
    for (int i = 0; i < NI; i++) begin
      if (cap && flt[i]) m_bits[i] = 1'b1;
      else if (wr && (i / 8 == addr) && wd[i % 8]) m_bits[i] = 1'b0;
    end
    m_any = 1'b0;
    for (int i = 0; i < NI; i++) if (m_bits[i]) m_any = 1'b1;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; capture_en = 0; fault_strobe = '0; host_wr = 0; host_rd = 0;
    host_addr = '0; host_wdata = '0;
    for (int i = 0; i < NI; i++) m_bits[i] = 0;
    m_rdata = '0; m_any = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset");
    rst = 1'b0;

    // R4: strobes with capture disabled change nothing
    step(0, 12'hFFF, 0, 0, 8'h00, 0, "R4 gated strobe");
    step(0, 12'h000, 0, 0, 8'h00, 1, "R4 read reg0");
    step(0, 12'h000, 0, 1, 8'h00, 1, "R4 read reg1");

    // R2: capture inputs 3 and 9
    step(1, 12'h208, 0, 0, 8'h00, 0, "R2 capture");
    step(0, 12'h000, 0, 0, 8'h00, 1, "R7 read reg0");
    step(0, 12'h000, 0, 1, 8'h00, 1, "R7 read reg1");

    // R3: bits hold over idle cycles
    for (int k = 0; k < 4; k++) step(1, 12'h000, 0, 0, 8'h00, 0, "R3 idle");
    step(0, 12'h000, 0, 0, 8'h00, 1, "R3 reg0 held");

    // R5: clear input 3 only
    step(0, 12'h000, 1, 0, 8'h08, 0, "R5 clear reg0 bit3");
    step(0, 12'h000, 0, 0, 8'h00, 1, "R5 reg0 cleared");
    step(0, 12'h000, 0, 1, 8'h00, 1, "R5 reg1 untouched");

    // R6: clear and enabled fault collide on input 9
    step(1, 12'h200, 1, 1, 8'h02, 1, "R6 collision with read");
    step(0, 12'h000, 0, 1, 8'h00, 1, "R6 fault wins");

    // R4 and R5: clear while a gated strobe is present
    step(0, 12'h200, 1, 1, 8'h02, 0, "R4 gated strobe vs clear");
    step(0, 12'h000, 0, 1, 8'h00, 1, "R4 bit cleared");

    // R7: all inputs, unused upper bits read zero
    step(1, 12'hFFF, 0, 0, 8'h00, 0, "R2 capture all");
    step(0, 12'h000, 0, 1, 8'h00, 1, "R7 reg1 upper zero");
    step(0, 12'h000, 0, 0, 8'h00, 1, "R7 reg0 full");

    // R8: summary follows the last remaining bits
    step(0, 12'h000, 1, 1, 8'hFF, 0, "R8 reg1 cleared, reg0 set");
    step(0, 12'h000, 1, 0, 8'h7F, 0, "R8 one bit left");
    step(0, 12'h000, 1, 0, 8'h80, 1, "R8 all clear");

    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      step($urandom_range(0, 1), NI'($urandom) & NI'($urandom), $urandom_range(0, 1),
           $urandom_range(0, 1), 8'($urandom), $urandom_range(0, 1), "R3 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule